// File: doc/BRIEF.md
# Instruction Register with Executor Dispatch

This block holds the current instruction word of a small nibble-wide processor. A five-bit word is captured in parallel from the shared data bus whenever the input decoder raises a load strobe. The four low bits are the instruction code; the top bit names the unit that may act on it. One unit is the arithmetic logic unit and the other is the general instruction processor for register and memory work. Each unit gets fifteen usable codes, thirty in all, with code zero reserved as a no-operation.

The code reaches the executors over a four-bit instruction bus that carries the command word only while the processor is in a write cycle. At all other times the bus is forced to zero, so both executors see a no-operation. The full five-bit word is always shown on a separate display output, whether or not the bus is gated.

Top module: `instr_dispatch_reg`

## Requirements
- R1: While `rst` is high at a rising clock edge, the stored word becomes zero: `ir_view` reads 0, `alu_en` is 1, `proc_en` is 0 and `instr_bus` reads 0.
- R2: When `load_en` is high and `rst` is low at a rising edge, the stored word takes the value of `bus_data`, and `ir_view` shows it from that edge on.
- R3: When `load_en` and `rst` are both low at a rising edge, the stored word keeps its value, whatever `bus_data` carries.
- R4: Bit 4 of the stored word selects the executor. A value of 0 drives `alu_en` high and `proc_en` low, and a value of 1 does the reverse. Exactly one enable is high in every cycle.
- R5: While `write_cycle` is high, `instr_bus` equals bits 3..0 of the stored word in the same cycle.
- R6: While `write_cycle` is low, `instr_bus` is 0000, which is the no-operation code for both executors.
- R7: `ir_view` always shows all five bits of the stored word, independent of `write_cycle`.
- R8: Reset has priority over load: with `rst` and `load_en` both high, the word becomes zero.

Top module port order follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_data | input | 5 | Shared data bus value to capture |
| load_en | input | 1 | Active-high load strobe from the input decoder |
| write_cycle | input | 1 | High during processor write cycles; opens the instruction bus |
| alu_en | output | 1 | Arithmetic unit may act on the code |
| proc_en | output | 1 | Instruction processor may act on the code |
| instr_bus | output | 4 | Gated instruction code, zero outside write cycles |
| ir_view | output | 5 | Raw stored word for the display |

## Verification
The stored word, `ir_view` and both enables change at the rising edge that samples `load_en` or `rst`. The bench therefore drives inputs on the falling edge and reads these outputs a quarter period after the next rising edge. `instr_bus` follows `write_cycle` in the same cycle with no register in the path, so it is read in that same sampling window against the model's word and the `write_cycle` level just driven. The behavioural model updates its integer word once per rising edge. It is compared in every cycle, including cycles where `bus_data` changes under a low strobe and cycles where reset and load coincide.

// File: rtl/ir_pkg.sv
package ir_pkg;

  // Executor chosen by the top bit of the stored instruction word.
  typedef enum logic {
    EXEC_ALU  = 1'b0,
    EXEC_PROC = 1'b1
  } exec_sel_e;

  localparam int NUM_EXEC = 2;

endpackage

// File: rtl/ir_word_reg.sv
module ir_word_reg #(
  parameter int WORD_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic [WORD_W-1:0] d,
  output logic [WORD_W-1:0] q
);

  logic [WORD_W-1:0] word_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
    end else if (load_en) begin
      word_q <= d;
    end
  end

  assign q = word_q;

  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    load_en |=> (q == $past(d)));  // R2

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !load_en |=> $stable(q));  // R3

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (q == '0));  // R1

endmodule

// File: rtl/ir_exec_select.sv
module ir_exec_select
  import ir_pkg::*;
#(
  parameter int NEXEC = NUM_EXEC
) (
  input  logic             clk,
  input  logic             rst,
  input  exec_sel_e        sel,
  output logic [NEXEC-1:0] exec_en
);

  // One enable per executor, generated from the selector value.
  for (genvar g = 0; g < NEXEC; g++) begin : g_exec
    assign exec_en[g] = (int'(sel) == g);
  end

  AST_ONE_EXECUTOR: assert property (@(posedge clk) disable iff (rst)
    $countones(exec_en) == 1);  // R4

endmodule

// File: rtl/ir_code_gate.sv
module ir_code_gate #(
  parameter int CODE_W = 4
) (
  input  logic              open_gate,
  input  logic [CODE_W-1:0] code_in,
  output logic [CODE_W-1:0] code_out
);

  // Per-bit cut-off: each bus line is an AND with the write-cycle level.
  for (genvar b = 0; b < CODE_W; b++) begin : g_bit
    assign code_out[b] = code_in[b] & open_gate;
  end

endmodule

// File: rtl/instr_dispatch_reg.sv
module instr_dispatch_reg
  import ir_pkg::*;
#(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W:0]   bus_data,
  input  logic              load_en,
  input  logic              write_cycle,
  output logic              alu_en,
  output logic              proc_en,
  output logic [CODE_W-1:0] instr_bus,
  output logic [CODE_W:0]   ir_view
);

  localparam int WORD_W = CODE_W + 1;
  localparam int SEL_BIT = WORD_W - 1;

  logic [WORD_W-1:0]   word;
  logic [NUM_EXEC-1:0] exec_en;
  exec_sel_e           sel;

  ir_word_reg #(.WORD_W(WORD_W)) u_word (
    .clk     (clk),
    .rst     (rst),
    .load_en (load_en),
    .d       (bus_data),
    .q       (word)
  );

  assign sel = exec_sel_e'(word[SEL_BIT]);

  ir_exec_select #(.NEXEC(NUM_EXEC)) u_sel (
    .clk     (clk),
    .rst     (rst),
    .sel     (sel),
    .exec_en (exec_en)
  );

  ir_code_gate #(.CODE_W(CODE_W)) u_gate (
    .open_gate (write_cycle),
    .code_in   (word[CODE_W-1:0]),
    .code_out  (instr_bus)
  );

  assign alu_en  = exec_en[EXEC_ALU];
  assign proc_en = exec_en[EXEC_PROC];
  assign ir_view = word;

  AST_BUS_OPEN: assert property (@(posedge clk) disable iff (rst)
    write_cycle |-> (instr_bus == ir_view[CODE_W-1:0]));  // R5

  AST_BUS_CLOSED: assert property (@(posedge clk) disable iff (rst)
    !write_cycle |-> (instr_bus == '0));  // R6

  AST_SEL_TRACK: assert property (@(posedge clk) disable iff (rst)
    proc_en == ir_view[SEL_BIT]);  // R4

endmodule

// File: tb/instr_dispatch_reg_bench.sv
module instr_dispatch_reg_bench;

  logic       clk = 1'b0;
  logic       rst;
  logic [4:0] bus_data;
  logic       load_en;
  logic       write_cycle;
  logic       alu_en;
  logic       proc_en;
  logic [3:0] instr_bus;
  logic [4:0] ir_view;

  int checks = 0;
  int fails  = 0;
  int model  = 0;
  int lfsr   = 32'h1D;
  bit done   = 0;

  always #10 clk = ~clk;

  instr_dispatch_reg u_instr_dispatch_reg (
    .clk(clk), .rst(rst), .bus_data(bus_data), .load_en(load_en),
    .write_cycle(write_cycle), .alu_en(alu_en), .proc_en(proc_en),
    .instr_bus(instr_bus), .ir_view(ir_view)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Drive on the falling edge, update the model at the rising edge,
  // compare every output 5 ns later.
  task automatic step(input int d, input bit ld, input bit wc, input bit r);
    @(negedge clk);
    bus_data = d[4:0]; load_en = ld; write_cycle = wc; rst = r;
    @(posedge clk);
    if (r) model = 0;            // R1, R8
    else if (ld) model = d & 31; // R2 ; otherwise hold, R3
    #5;
    chk("R7 ir_view", int'(ir_view), model);
    chk("R4 alu_en", int'(alu_en), ((model >> 4) & 1) == 0 ? 1 : 0);
    chk("R4 proc_en", int'(proc_en), (model >> 4) & 1);
    chk(wc ? "R5 instr_bus open" : "R6 instr_bus closed",
        int'(instr_bus), wc ? (model & 15) : 0);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1; load_en = 0; write_cycle = 0; bus_data = 0;
    step(0, 0, 1, 1);            // R1 reset state
    step(5'h07, 1, 1, 0);        // R2 load ALU code, bus open
    step(5'h07, 0, 0, 0);        // R6 closed
    step(5'h1A, 0, 1, 0);        // R3 hold despite bus change
    step(5'h1A, 1, 1, 0);        // R2 load processor code, R4
    step(5'h03, 0, 0, 0);        // R3, R6
    step(5'h1F, 1, 0, 0);        // R7 view while closed
    step(5'h1F, 0, 1, 0);        // R5
    step(5'h10, 1, 1, 0);        // proc nop code
    step(5'h0F, 1, 1, 1);        // R8 reset beats load
    step(5'h0F, 0, 1, 0);        // stays zero after reset
    for (int i = 0; i < 200; i++) begin
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB8 : 0);
      step(lfsr & 31, (lfsr >> 5) & 1, (lfsr >> 6) & 1, (i % 53) == 52);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule